// File: doc/BRIEF.md
# Multi-Rail Enable and Fault Supervisor

This block is the digital sequencing and protection core of a five-output power controller: two standby linear outputs, two main buck rails and a boost rail that follows the first buck. It receives a master run input, a per-buck enable, and the outputs of analog comparators as logic flags. These flags are input under-voltage, over-temperature, and per-buck over-current, under-voltage, over-voltage and soft-start-complete. From these it produces the enables for the standby and buck outputs, pulse-skip requests, low-side force (soft crowbar) requests, fault gate-off commands, an open-drain style power-good pull-down and a per-rail record of the latched fault cause.

Every input except the switching tick passes through a two-flop synchroniser. Outputs follow the synchronised state combinationally, or through the fault latches. Time windows are cycle counts derived from the clock frequency parameter. Over-current is qualified on the switching tick `sw_tick`, a one-cycle pulse that is already in the `clk` domain. Under-voltage and over-current faults latch. Over-voltage forcing and over-temperature shutdown clear by themselves.

Top module: `rail_supervisor`

## Requirements
- R1: With `master_on` low, `stby_en`, `buck_en` and `ls_force` are all zero, whatever `rail_en` holds.
- R2: With `master_on` high and neither `vin_low` nor `over_temp` set, `stby_en` is 1 and `buck_en[i]` is 1 exactly when `rail_en[i]` is high and rail i holds no latched fault; `gate_off` is then zero.
- R3: An under-voltage flag on a running rail whose `ss_done` is high, held for the under-voltage window (UV_DELAY_NS of clock), latches both buck rails off: `buck_en` all 0, `gate_off` all 1. A shorter flag has no effect.
- R4: While rail i runs with its over-current flag high, `pulse_skip[i]` is 1. OC_LIMIT consecutive `sw_tick` pulses with the flag high latch rail i off (`buck_en[i]`=0, `gate_off[i]`=1), and the other rail is unaffected. A flag that drops before that restarts the count.
- R5: An over-voltage flag on running rail i sets `ls_force[i]` for rail i only. The force falls as soon as the flag falls and leaves no latch behind.
- R6: Latched faults survive toggling `rail_en` and are cleared only by `master_on` low or `vin_low` high.
- R7: `over_temp` turns off `stby_en` and all `buck_en` and sets all `gate_off`. When it clears, operation resumes and existing fault latches are kept.
- R8: `vin_low` holds all outputs off with `gate_off` all 1 while asserted, and clears the fault latches.
- R9: `pg_pull_dn` is 0 (power good) only when every buck rail runs, has `ss_done` high and has its under-voltage flag low.
- R10: Once `pg_pull_dn` rises, it stays 1 for at least PG_MIN_LOW_NS of clock, even if the good condition returns sooner.
- R11: `fault_rec` holds two bits per rail: bit 2i is the over-current latch of rail i, and bit 2i+1 marks rail i as the source of an under-voltage latch. The record clears together with the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_tick | input | 1 | One-cycle pulse per switching period, in the clk domain |
| master_on | input | 1 | Master run input; low shuts everything down |
| rail_en | input | NR | Per-buck enable |
| vin_low | input | 1 | Input supply under-voltage flag |
| over_temp | input | 1 | Die over-temperature flag |
| oc_flag | input | NR | Per-buck over-current flag |
| uv_flag | input | NR | Per-buck output under-voltage flag |
| ov_flag | input | NR | Per-buck output over-voltage flag |
| ss_done | input | NR | Per-buck soft-start complete |
| stby_en | output | 1 | Enable for both standby linear outputs |
| buck_en | output | NR | Per-buck run enable |
| pulse_skip | output | NR | Per-buck pulse-skip request on over-current |
| ls_force | output | NR | Per-buck low-side gate force on over-voltage |
| gate_off | output | NR | Per-buck command holding both gates low |
| pg_pull_dn | output | 1 | 1 drives the power-good line low |
| fault_rec | output | 2*NR | Latched fault cause per rail |

## Verification
The bench builds the block with CLK_MHZ=10. This shrinks the 2 µs under-voltage window to 20 cycles and the 10 µs power-good low time to 100 cycles. OC_LIMIT stays at 8 with a tick every fourth cycle. At these values a short under-voltage glitch and a latching one, and a non-consecutive and a consecutive over-current run, each fit in a few dozen cycles. The full power-good stretch can also be watched both before and after it expires.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;

  typedef struct packed {
    logic uv;
    logic oc;
  } rail_fault_t;

  function automatic int ns_to_cycles(input int mhz, input int ns);
    int c;
    c = (mhz * ns + 999) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/oc_guard.sv
module oc_guard #(
  parameter int OC_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flag,
  input  logic run,
  input  logic clr,
  output logic latched
);
  localparam int CW = $clog2(OC_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(OC_LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      latched <= 1'b0;
    end else if (clr) begin
      cnt     <= '0;
      latched <= 1'b0;
    end else if (!latched) begin
      if (!(flag && run)) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) latched <= 1'b1;
        else             cnt     <= cnt + 1'b1;
      end
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(OC_LIMIT));
  a_r6_oc_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !clr) |=> latched);
  a_r4_latch_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched) |-> $past(tick && flag));
endmodule

// File: rtl/uv_guard.sv
module uv_guard #(
  parameter int NR     = 2,
  parameter int UV_CYC = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] uv,
  input  logic [NR-1:0] arm,
  input  logic          clr,
  output logic [NR-1:0] who
);
  localparam int CW = $clog2(UV_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(UV_CYC - 1);

  logic [CW-1:0] cnt;
  logic [NR-1:0] hit;
  logic          busy;

  assign hit  = uv & arm;
  assign busy = |who;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      who <= '0;
    end else if (clr) begin
      cnt <= '0;
      who <= '0;
    end else if (!busy) begin
      if (|hit) begin
        if (cnt == LAST) who <= hit;
        else             cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end

  a_r3_uv_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr) |=> (who == $past(who)));
  a_r3_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cnt) == LAST && $past(|hit)));
endmodule

// File: rtl/pg_stretch.sv
module pg_stretch #(
  parameter int PG_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good,
  output logic pg_pull_dn
);
  localparam int PW = $clog2(PG_CYC + 1);

  logic          pg_q;
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      cnt  <= '0;
    end else if (pg_q && !good) begin
      pg_q <= 1'b0;
      cnt  <= PW'(PG_CYC - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (good) begin
      pg_q <= 1'b1;
    end
  end

  assign pg_pull_dn = ~pg_q;

  a_r10_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> !pg_q);
  a_r10_drop_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_q && !good) |=> !pg_q);
  a_r9_rise_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_q) |-> $past(good));
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor #(
  parameter int NR            = 2,
  parameter int CLK_MHZ       = 200,
  parameter int UV_DELAY_NS   = 2000,
  parameter int PG_MIN_LOW_NS = 10000,
  parameter int OC_LIMIT      = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_tick,
  input  logic            master_on,
  input  logic [NR-1:0]   rail_en,
  input  logic            vin_low,
  input  logic            over_temp,
  input  logic [NR-1:0]   oc_flag,
  input  logic [NR-1:0]   uv_flag,
  input  logic [NR-1:0]   ov_flag,
  input  logic [NR-1:0]   ss_done,
  output logic            stby_en,
  output logic [NR-1:0]   buck_en,
  output logic [NR-1:0]   pulse_skip,
  output logic [NR-1:0]   ls_force,
  output logic [NR-1:0]   gate_off,
  output logic            pg_pull_dn,
  output logic [2*NR-1:0] fault_rec
);
  import rail_sup_pkg::*;

  localparam int UV_CYC = ns_to_cycles(CLK_MHZ, UV_DELAY_NS);
  localparam int PG_CYC = ns_to_cycles(CLK_MHZ, PG_MIN_LOW_NS);
  localparam int SW     = 3 + 5 * NR;

  logic [SW-1:0] raw, syn;
  logic          m_s, vin_s, ot_s;
  logic [NR-1:0] en_s, oc_s, uv_s, ov_s, ss_s;

  assign raw = {ss_done, ov_flag, uv_flag, oc_flag, rail_en, over_temp, vin_low, master_on};

  flag_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign m_s   = syn[0];
  assign vin_s = syn[1];
  assign ot_s  = syn[2];
  assign en_s  = syn[3 +: NR];
  assign oc_s  = syn[3 + NR +: NR];
  assign uv_s  = syn[3 + 2*NR +: NR];
  assign ov_s  = syn[3 + 3*NR +: NR];
  assign ss_s  = syn[3 + 4*NR +: NR];

  logic          clr, up, uv_lat;
  logic [NR-1:0] uv_who, oc_lat, run_ok, arm;
  rail_fault_t [NR-1:0] rec;

  assign clr     = ~m_s | vin_s;
  assign up      = m_s & ~vin_s & ~ot_s;
  assign uv_lat  = |uv_who;
  assign stby_en = up;

  genvar i;
  generate
    for (i = 0; i < NR; i++) begin : g_rail
      assign run_ok[i]     = up & en_s[i] & ~uv_lat & ~oc_lat[i];
      assign arm[i]        = run_ok[i] & ss_s[i];
      assign buck_en[i]    = run_ok[i];
      assign pulse_skip[i] = run_ok[i] & oc_s[i];
      assign ls_force[i]   = run_ok[i] & ov_s[i];
      assign gate_off[i]   = uv_lat | oc_lat[i] | ot_s | vin_s;
      assign rec[i].oc     = oc_lat[i];
      assign rec[i].uv     = uv_who[i];

      oc_guard #(.OC_LIMIT(OC_LIMIT)) u_oc (
        .clk(clk), .rst_n(rst_n), .tick(sw_tick), .flag(oc_s[i]),
        .run(run_ok[i]), .clr(clr), .latched(oc_lat[i])
      );
    end
  endgenerate

  assign fault_rec = rec;

  uv_guard #(.NR(NR), .UV_CYC(UV_CYC)) u_uv (
    .clk(clk), .rst_n(rst_n), .uv(uv_s), .arm(arm), .clr(clr), .who(uv_who)
  );

  pg_stretch #(.PG_CYC(PG_CYC)) u_pg (
    .clk(clk), .rst_n(rst_n), .good(&(ss_s & run_ok & ~uv_s)), .pg_pull_dn(pg_pull_dn)
  );

  a_r1_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !m_s |-> (!stby_en && buck_en == '0 && ls_force == '0));
  a_r5_force_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_force & ~ov_s) == '0);
  a_r7_hot_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    ot_s |-> (!stby_en && buck_en == '0 && gate_off == '1));
  a_r8_clear_on_vin_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vin_s) |-> (fault_rec == '0));
endmodule

// File: tb/rail_supervisor_test.sv
`timescale 1ns/1ps
module rail_supervisor_test;
  localparam int NR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_tick = 1'b0;
  logic master_on = 1'b0, vin_low = 1'b0, over_temp = 1'b0;
  logic [NR-1:0] rail_en = '0, oc_flag = '0, uv_flag = '0, ov_flag = '0, ss_done = '0;
  logic stby_en, pg_pull_dn;
  logic [NR-1:0] buck_en, pulse_skip, ls_force, gate_off;
  logic [2*NR-1:0] fault_rec;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rail_supervisor #(.NR(NR), .CLK_MHZ(10), .UV_DELAY_NS(2000), .PG_MIN_LOW_NS(10000),
                    .OC_LIMIT(8), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .sw_tick(sw_tick), .master_on(master_on), .rail_en(rail_en),
    .vin_low(vin_low), .over_temp(over_temp), .oc_flag(oc_flag), .uv_flag(uv_flag),
    .ov_flag(ov_flag), .ss_done(ss_done), .stby_en(stby_en), .buck_en(buck_en),
    .pulse_skip(pulse_skip), .ls_force(ls_force), .gate_off(gate_off),
    .pg_pull_dn(pg_pull_dn), .fault_rec(fault_rec)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      sw_tick = 1'b1;
      @(negedge clk);
      sw_tick = 1'b0;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic t_reset;
    check("R1", "stby after reset", 8'(stby_en), 8'h0);
    check("R1", "buck after reset", 8'(buck_en), 8'h0);
    check("R9", "pg after reset", 8'(pg_pull_dn), 8'h1);
    check("R11", "record after reset", 8'(fault_rec), 8'h0);
  endtask

  task automatic t_master;
    rail_en = 2'b11; step(5);
    check("R1", "buck with master low", 8'(buck_en), 8'h0);
    check("R1", "stby with master low", 8'(stby_en), 8'h0);
    master_on = 1'b1; rail_en = 2'b01; step(5);
    check("R2", "stby on", 8'(stby_en), 8'h1);
    check("R2", "buck one rail", 8'(buck_en), 8'h1);
    check("R2", "gates free", 8'(gate_off), 8'h0);
    rail_en = 2'b11; step(5);
    check("R2", "buck both", 8'(buck_en), 8'h3);
  endtask

  task automatic t_pgood;
    step(5);
    check("R9", "pg without soft start", 8'(pg_pull_dn), 8'h1);
    ss_done = 2'b01; step(5);
    check("R9", "pg one soft start", 8'(pg_pull_dn), 8'h1);
    ss_done = 2'b11; step(5);
    check("R9", "pg all good", 8'(pg_pull_dn), 8'h0);
  endtask

  task automatic t_pg_low;
    ss_done = 2'b10; step(1); ss_done = 2'b11;
    step(50);
    check("R10", "pg still held low", 8'(pg_pull_dn), 8'h1);
    step(70);
    check("R10", "pg released after window", 8'(pg_pull_dn), 8'h0);
  endtask

  task automatic t_uv_short;
    uv_flag = 2'b01; step(10); uv_flag = 2'b00; step(5);
    check("R3", "short uv no latch", 8'(buck_en), 8'h3);
    check("R3", "short uv no record", 8'(fault_rec), 8'h0);
    step(110);
  endtask

  task automatic t_ov;
    ov_flag = 2'b10; step(5);
    check("R5", "force on rail1 only", 8'(ls_force), 8'h2);
    check("R5", "rails keep running", 8'(buck_en), 8'h3);
    ov_flag = 2'b00; step(5);
    check("R5", "force released", 8'(ls_force), 8'h0);
    check("R5", "no latch left", 8'(fault_rec), 8'h0);
  endtask

  task automatic t_oc_short;
    oc_flag = 2'b01; step(6);
    check("R4", "skip during oc", 8'(pulse_skip), 8'h1);
    step(4); oc_flag = 2'b00; step(4);
    oc_flag = 2'b01; step(20); oc_flag = 2'b00; step(5);
    check("R4", "broken oc run no latch", 8'(buck_en), 8'h3);
    check("R4", "skip ends", 8'(pulse_skip), 8'h0);
  endtask

  task automatic t_oc_latch;
    oc_flag = 2'b01; step(60); oc_flag = 2'b00; step(5);
    check("R4", "rail0 latched off", 8'(buck_en), 8'h2);
    check("R4", "rail0 gates off", 8'(gate_off), 8'h1);
    check("R11", "oc record rail0", 8'(fault_rec), 8'h1);
    rail_en = 2'b00; step(5); rail_en = 2'b11; step(5);
    check("R6", "enable toggle keeps latch", 8'(buck_en), 8'h2);
    master_on = 1'b0; step(5);
    check("R1", "master low stby off", 8'(stby_en), 8'h0);
    master_on = 1'b1; step(5);
    check("R6", "master cycle clears", 8'(buck_en), 8'h3);
    check("R11", "record cleared", 8'(fault_rec), 8'h0);
  endtask

  task automatic t_uv_latch;
    uv_flag = 2'b10; step(40);
    check("R3", "both bucks off", 8'(buck_en), 8'h0);
    check("R3", "both gates off", 8'(gate_off), 8'h3);
    check("R11", "uv record rail1", 8'(fault_rec), 8'h8);
    uv_flag = 2'b00; step(10);
    check("R6", "uv latch holds", 8'(buck_en), 8'h0);
    vin_low = 1'b1; step(5);
    check("R8", "vin low stby off", 8'(stby_en), 8'h0);
    check("R8", "vin low gates off", 8'(gate_off), 8'h3);
    check("R8", "vin low clears record", 8'(fault_rec), 8'h0);
    vin_low = 1'b0; step(5);
    check("R8", "recovered after vin", 8'(buck_en), 8'h3);
  endtask

  task automatic t_ot;
    oc_flag = 2'b10; step(60); oc_flag = 2'b00; step(5);
    check("R11", "oc record rail1", 8'(fault_rec), 8'h4);
    over_temp = 1'b1; step(5);
    check("R7", "hot stby off", 8'(stby_en), 8'h0);
    check("R7", "hot bucks off", 8'(buck_en), 8'h0);
    check("R7", "hot gates off", 8'(gate_off), 8'h3);
    over_temp = 1'b0; step(5);
    check("R7", "cool stby back", 8'(stby_en), 8'h1);
    check("R7", "cool latch kept", 8'(buck_en), 8'h1);
    check("R7", "cool record kept", 8'(fault_rec), 8'h4);
    master_on = 1'b0; step(5); master_on = 1'b1; step(5);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_master();
    t_pgood();
    t_pg_low();
    t_ov();
    t_uv_short();
    t_oc_short();
    t_oc_latch();
    t_uv_latch();
    t_ot();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule